// File: doc/BRIEF.md
# Count-Compare Timer and Interrupt Gate

This block keeps a free-running tick counter and a software-loaded match value. When the two are equal it latches a timer pending flag. The flag stays set until software next loads the match value. The block also holds the processor mode word: the per-source enable mask, the global enable, and the exception-level and error-level bits. It merges the timer flag, five level-sensitive hardware interrupt lines and two software-set pending bits with that mask. The result is a single interrupt request to the core.

Software reaches four registers through a simple port: address, write enable and write data, with a combinational read data bus. The counter advances on each cycle in which `tick_en` is high. The mode word stores its coprocessor-enable, endian-reverse, diagnostic and privilege fields without acting on them.

Register addresses: 0 = counter, 1 = match value, 2 = mode word, 3 = pending view.

Top module: `tick_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, the registers read as follows: counter 0, match value 0, mode word 0x00000004 (error level set), pending view 0. `irq_req` is 0.
- R2: On each clock edge where `tick_en` is 1 and the counter is not written, the counter rises by one, wrapping from 0xFFFFFFFF to 0. With `tick_en` at 0 it holds its value.
- R3: A write to address 0 loads the counter with the write data. The write takes priority over a tick in the same cycle.
- R4: The match value changes only when address 1 is written, and it reads back the last value written.
- R5: When the counter equals the match value at a clock edge, the timer pending flag is set after that edge. It then stays set while the counter moves on.
- R6: Any write to address 1 clears the timer pending flag after the write edge, whatever value is written. This also holds in a cycle where counter and match value are equal.
- R7: In the mode word only bits 28, 25, 24:22, 20:16 and 15:0 are writable. Bit 21 and all other bits read as 0, so writing 0xFFFFFFFF reads back 0x13DFFFFF.
- R8: The pending view at address 3 shows the eight pending bits in bits 15:8. Bit 15 is the timer flag. Bits 14:10 follow `hw_irq[4:0]` level by level. Bits 9:8 are the software bits, loaded from write data bits 9:8 by a write to address 3. All other bits read 0.
- R9: Mode word bits 15:8 are the enable mask, aligned bit for bit with the pending bits. A 1 enables the source. `irq_req` is 1 when at least one pending bit has its mask bit set and the gate of R10 is open.
- R10: `irq_req` is 0 whenever mode bit 0 (global enable) is 0, mode bit 1 (exception level) is 1, or mode bit 2 (error level) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance enable |
| reg_addr | input | ADDR_W (2) | Register address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | DATA_W (32) | Register write data |
| reg_rdata | output | DATA_W (32) | Register read data, combinational on `reg_addr` |
| hw_irq | input | HW_LINES (5) | Level-sensitive hardware interrupt lines |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
The properties assume that every register write lasts one clock with stable address and data. They also assume that `tick_en` and `hw_irq` change only between clock edges, so each edge has a well-defined count step and match outcome. The bench drives every input on the falling edge, issues writes as single-cycle pulses, and holds `tick_en` low whenever it loads a counter or match value it later compares against. Timer-flag expectations therefore depend only on the counted number of rising edges.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;
   localparam int unsigned RA_COUNT  = 0;
   localparam int unsigned RA_MATCH  = 1;
   localparam int unsigned RA_MODE   = 2;
   localparam int unsigned RA_PEND   = 3;

   localparam int unsigned MB_IE     = 0;
   localparam int unsigned MB_EXL    = 1;
   localparam int unsigned MB_ERL    = 2;
   localparam int unsigned MB_MASK   = 8;
   localparam int unsigned MB_RDONLY = 21;
   localparam int unsigned PEND_LO   = 8;
   localparam int unsigned NUM_SRC   = 8;

   function automatic logic [31:0] mode_wmask();
      logic [31:0] m;
      m = 32'h0000_FFFF;
      m[28] = 1'b1;
      m[25] = 1'b1;
      for (int b = 16; b <= 24; b++) m[b] = 1'b1;
      m[MB_RDONLY] = 1'b0;
      return m;
   endfunction

   localparam logic [31:0] MODE_WMASK = mode_wmask();
   localparam logic [31:0] MODE_RST   = 32'h0000_0004;
endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_en,
   input  logic         cnt_we,
   input  logic         cmp_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] cnt_q,
   output logic [W-1:0] cmp_q,
   output logic         tpend_q
);
   localparam logic [W-1:0] ONE = W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_we) begin
         cnt_q <= wdata;
      end else if (tick_en) begin
         cnt_q <= cnt_q + ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q   <= '0;
         tpend_q <= 1'b0;
      end else if (cmp_we) begin
         cmp_q   <= wdata;
         tpend_q <= 1'b0;
      end else if (cnt_q == cmp_q) begin
         tpend_q <= 1'b1;
      end
   end
endmodule

// File: rtl/mode_word.sv
module mode_word
   import tick_irq_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] mode_q
);
   localparam logic [W-1:0] WMASK = W'(MODE_WMASK);
   localparam logic [W-1:0] RSTV  = W'(MODE_RST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= RSTV;
      end else if (we) begin
         mode_q <= wdata & WMASK;
      end
   end
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
   parameter int unsigned NSRC = 8
) (
   input  logic [NSRC-1:0] pend,
   input  logic [NSRC-1:0] mask,
   input  logic            gen_en,
   input  logic            exc_lvl,
   input  logic            err_lvl,
   output logic            irq_req
);
   logic [NSRC-1:0] live;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign live[i] = pend[i] & mask[i];
   end

   assign irq_req = gen_en & ~exc_lvl & ~err_lvl & (|live);
endmodule

// File: rtl/tick_irq_ctrl.sv
module tick_irq_ctrl
   import tick_irq_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned HW_LINES = 5,
   parameter int unsigned SW_BITS  = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_en,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic                reg_we,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic [HW_LINES-1:0] hw_irq,
   output logic                irq_req
);
   localparam int unsigned NSRC   = 1 + HW_LINES + SW_BITS;
   localparam int unsigned TMR_IX = NSRC - 1;

   if (DATA_W < 29) begin : g_bad_width
      $error("tick_irq_ctrl: DATA_W must hold the mode word layout");
   end
   if (NSRC != NUM_SRC) begin : g_bad_src
      $error("tick_irq_ctrl: sources must fill the 8-bit mask field");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("tick_irq_ctrl: ADDR_W must reach four registers");
   end

   logic              cnt_we, cmp_we, mode_we, pend_we;
   logic [DATA_W-1:0] cnt_q, cmp_q, mode_q;
   logic              tpend_q;
   logic [SW_BITS-1:0] swp_q;
   logic [NSRC-1:0]   pend;
   logic [DATA_W-1:0] pend_view;

   assign cnt_we  = reg_we && (reg_addr == ADDR_W'(RA_COUNT));
   assign cmp_we  = reg_we && (reg_addr == ADDR_W'(RA_MATCH));
   assign mode_we = reg_we && (reg_addr == ADDR_W'(RA_MODE));
   assign pend_we = reg_we && (reg_addr == ADDR_W'(RA_PEND));

   tick_counter #(.W(DATA_W)) cnt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .cnt_we  (cnt_we),
      .cmp_we  (cmp_we),
      .wdata   (reg_wdata),
      .cnt_q   (cnt_q),
      .cmp_q   (cmp_q),
      .tpend_q (tpend_q)
   );

   mode_word #(.W(DATA_W)) mode_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (mode_we),
      .wdata  (reg_wdata),
      .mode_q (mode_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         swp_q <= '0;
      end else if (pend_we) begin
         swp_q <= reg_wdata[PEND_LO +: SW_BITS];
      end
   end

   assign pend = {tpend_q, hw_irq, swp_q};

   always_comb begin
      pend_view = '0;
      pend_view[PEND_LO +: NSRC] = pend;
   end

   irq_merge #(.NSRC(NSRC)) merge_i (
      .pend    (pend),
      .mask    (mode_q[MB_MASK +: NSRC]),
      .gen_en  (mode_q[MB_IE]),
      .exc_lvl (mode_q[MB_EXL]),
      .err_lvl (mode_q[MB_ERL]),
      .irq_req (irq_req)
   );

   always_comb begin
      case (reg_addr)
         ADDR_W'(RA_COUNT): reg_rdata = cnt_q;
         ADDR_W'(RA_MATCH): reg_rdata = cmp_q;
         ADDR_W'(RA_MODE):  reg_rdata = mode_q;
         ADDR_W'(RA_PEND):  reg_rdata = pend_view;
         default:           reg_rdata = '0;
      endcase
   end

   wire unused_tmr_ix = (TMR_IX == 0);
endmodule

// File: rtl/tick_irq_chk.sv
module tick_irq_chk
   import tick_irq_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] cnt_q,
   input logic [DATA_W-1:0] cmp_q,
   input logic              tpend_q,
   input logic [DATA_W-1:0] mode_q,
   input logic              irq_req
);
   logic wr_cnt, wr_cmp;
   assign wr_cnt = reg_we && (reg_addr == ADDR_W'(RA_COUNT));
   assign wr_cmp = reg_we && (reg_addr == ADDR_W'(RA_MATCH));

   p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !wr_cnt) |=> (cnt_q == DATA_W'($past(cnt_q) + DATA_W'(1))));

   p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !wr_cnt) |=> $stable(cnt_q));

   p_match_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cmp |=> $stable(cmp_q));

   p_match_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == cmp_q && !wr_cmp) |=> tpend_q);

   p_flag_sticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tpend_q && !wr_cmp) |=> tpend_q);

   p_match_wr_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmp |=> !tpend_q);

   p_mode_ro_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q & ~DATA_W'(MODE_WMASK)) == '0);

   p_gate_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q[MB_IE] || mode_q[MB_EXL] || mode_q[MB_ERL]) |-> !irq_req);
endmodule

bind tick_irq_ctrl tick_irq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_en  (tick_en),
   .reg_we   (reg_we),
   .reg_addr (reg_addr),
   .cnt_q    (cnt_q),
   .cmp_q    (cmp_q),
   .tpend_q  (tpend_q),
   .mode_q   (mode_q),
   .irq_req  (irq_req)
);

// File: tb/tick_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module tick_irq_ctrl_tb_top;
   localparam int A_CNT = 0, A_CMP = 1, A_MODE = 2, A_PEND = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [4:0]  hw_irq = '0;
   logic        irq_req;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   tick_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .hw_irq(hw_irq), .irq_req(irq_req)
   );

   // vector: mode word, hw lines, sw bits, expected request
   localparam logic [39:0] VECS [0:10] = '{
      {32'h0000_FF01, 5'b00001, 2'b00, 1'b1},
      {32'h0000_FB01, 5'b00001, 2'b00, 1'b0},
      {32'h0000_0101, 5'b00000, 2'b01, 1'b1},
      {32'h0000_0201, 5'b00000, 2'b01, 1'b0},
      {32'h0000_0203, 5'b00000, 2'b10, 1'b0},
      {32'h0000_0205, 5'b00000, 2'b10, 1'b0},
      {32'h0000_0200, 5'b00000, 2'b10, 1'b0},
      {32'h0000_0201, 5'b00000, 2'b10, 1'b1},
      {32'h0000_8001, 5'b10000, 2'b00, 1'b0},
      {32'h0000_4001, 5'b10000, 2'b00, 1'b1},
      {32'h0000_0001, 5'b11111, 2'b11, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = 2'(a); reg_we = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      reg_addr = 2'(a);
      #1 d = reg_rdata;
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rd(A_CNT, v);  check("R1 count", v, 32'h0);
      rd(A_CMP, v);  check("R1 match", v, 32'h0);
      rd(A_MODE, v); check("R1 mode", v, 32'h4);
      rd(A_PEND, v); check("R1 pend", v, 32'h0);
      check("R1 irq", {31'b0, irq_req}, 32'h0);
      @(negedge clk); rst_n = 1'b1;

      wr(A_CMP, 32'hFFFF_0000);
      rd(A_CMP, v); check("R4 match readback", v, 32'hFFFF_0000);
      wr(A_MODE, 32'hFFFF_FFFF);
      rd(A_MODE, v); check("R7 writable mask", v, 32'h13DF_FFFF);

      // R9 R10 vector walk
      for (int i = 0; i < 11; i++) begin
         wr(A_MODE, VECS[i][39:8]);
         wr(A_PEND, {22'b0, VECS[i][2:1], 8'b0});
         hw_irq = VECS[i][7:3];
         rd(A_PEND, v);
         check("R8 pend view", v, {17'b0, 1'b0, VECS[i][7:3], VECS[i][2:1], 8'b0});
         check((i == 4 || i == 5 || i == 6) ? "R10 gate" : "R9 mask",
               {31'b0, irq_req}, {31'b0, VECS[i][0]});
      end
      hw_irq = '0;
      wr(A_PEND, 32'h0);
      wr(A_MODE, 32'h0);

      // R2 wrap
      wr(A_CNT, 32'hFFFF_FFFE);
      wr(A_CMP, 32'h10);
      rd(A_CNT, v); check("R2 hold", v, 32'hFFFF_FFFE);
      tick_en = 1'b1;
      @(negedge clk); @(negedge clk);
      tick_en = 1'b0;
      rd(A_CNT, v); check("R2 wrap", v, 32'h0);

      // R3 write beats tick
      tick_en = 1'b1;
      wr(A_CNT, 32'h1234);
      tick_en = 1'b0;
      rd(A_CNT, v); check("R3 write wins", v, 32'h1234);

      // R5 match sets sticky flag
      wr(A_CNT, 32'h2);
      wr(A_CMP, 32'h5);
      tick_en = 1'b1;
      @(negedge clk); @(negedge clk);
      tick_en = 1'b0;
      rd(A_PEND, v); check("R5 no early flag", v, 32'h0);
      tick_en = 1'b1;
      repeat (4) @(negedge clk);
      tick_en = 1'b0;
      rd(A_CNT, v);  check("R5 count moved on", v, 32'h8);
      rd(A_PEND, v); check("R5 flag held", v, 32'h8000);
      wr(A_MODE, 32'h0000_8001);
      check("R9 timer enabled", {31'b0, irq_req}, 32'h1);
      wr(A_MODE, 32'h0000_0001);
      check("R9 timer masked", {31'b0, irq_req}, 32'h0);
      wr(A_MODE, 32'h0000_8001);

      // R6 clear by write
      wr(A_CMP, 32'h100);
      rd(A_PEND, v); check("R6 cleared", v, 32'h0);
      check("R6 irq drops", {31'b0, irq_req}, 32'h0);
      wr(A_CNT, 32'h20);
      wr(A_CMP, 32'h20);
      rd(A_PEND, v); check("R6 cleared on write edge", v, 32'h0);
      @(negedge clk);
      rd(A_PEND, v); check("R5 set on match", v, 32'h8000);
      wr(A_CMP, 32'h20);
      rd(A_PEND, v); check("R6 write beats match", v, 32'h0);
      rd(A_CMP, v);  check("R4 match kept", v, 32'h20);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule